// File: doc/BRIEF.md
# I2C Open-Drain Pin Controller with Deferred SDA Update

This block sits between the serial shift engine of an I2C-capable serial unit and three chip pins. With the I2C mode input set, one pin carries SDA, another carries SCL, and the third remains an ordinary port pin. Both bus pins are open-drain. An output enable pulls the pin low, and releasing it lets the external pull-up raise the line. Both pin inputs pass through a two-flop synchronizer before the block uses them for any level or edge decision. The synchronized levels are also reported back as read values. The SCL read value is always the real pin level, whatever the block is driving.

Data bits from the shift engine arrive on a valid/ready stream. An accepted bit waits in a one-entry holding slot. It reaches the SDA pin only after the synchronized SCL has been low for a programmable number of system clocks, so SDA never moves while SCL is high or still falling. `tx_ready` is high only in I2C mode with the slot empty. A bit offered while `tx_ready` is low is not taken, and the source must hold it until a handshake occurs. Out of I2C mode the SDA output register tracks the SDA port data latch. The first SDA level after the mode is entered is therefore that latch value.

SCL is pulled low when the clock generator's level is low or when the SCL data latch holds 0. The latch can be written directly. An optional hold mode clears the latch on every synchronized SCL fall, which keeps the clock stretched until the latch is written back to 1.

Top module: `i2c_pin_ctrl`

## Requirements
- R1: After reset `sda_oe`=0, `scl_oe`=0, `tx_ready`=0, `scl_latch_q`=1 and `sda_dly_q`=2.
- R2: While `i2c_mode`=0, `sda_oe`=0, `scl_oe`=0 and `tx_ready`=0. A held bit is discarded, and `tx_valid` has no effect on `sda_oe`.
- R3: When `i2c_mode` rises, `sda_oe` in that same cycle equals the inverse of the `sda_port_q` value sampled at the previous clock edge. A port bit of 1 releases SDA; a port bit of 0 pulls it low.
- R4: A held bit b sets `sda_oe` to !b right after clock edge k0+2+D. Here k0 is the first edge at which the SCL pin is sampled low, and D is `sda_dly_q`. Before that edge `sda_oe` keeps its old value.
- R5: While the synchronized SCL is high, a held bit is never applied to SDA.
- R6: `tx_ready` = `i2c_mode` AND slot empty. A bit is taken only on an edge with `tx_valid`=1 and `tx_ready`=1. The slot empties on the edge that applies the bit. With SCL already settled low, a taken bit is applied on the next edge.
- R7: `scl_level` and `sda_level` equal the pin levels sampled two edges earlier, whatever `scl_oe` and `sda_oe` are.
- R8: With `i2c_mode`=1 and `scl_hold_en`=1, `scl_latch_q` becomes 0 right after edge k0+2 of each SCL pin fall. A write on `scl_latch_wr` in the same cycle takes priority.
- R9: With `scl_hold_en`=0, an SCL fall leaves `scl_latch_q` unchanged. Only `scl_latch_wr` loads it.
- R10: `scl_oe` = `i2c_mode` AND (`gen_scl`=0 OR `scl_latch_q`=0).
- R11: `gp_oe` equals `gp_drive_low` in either mode.
- R12: `sda_dly_wr`=1 at an edge loads `sda_dly_in` into `sda_dly_q`. A value of 0 applies the bit at edge k0+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i2c_mode | input | 1 | I2C mode enable |
| sda_port_q | input | 1 | SDA port data latch value |
| tx_valid | input | 1 | Serial bit offered by the shift engine |
| tx_bit | input | 1 | Serial data bit |
| tx_ready | output | 1 | Holding slot can take a bit |
| gen_scl | input | 1 | Clock generator SCL level (0 pulls SCL) |
| scl_hold_en | input | 1 | Clear SCL latch on each SCL fall |
| scl_latch_wr | input | 1 | SCL data latch write strobe |
| scl_latch_wdata | input | 1 | SCL data latch write value |
| scl_latch_q | output | 1 | SCL data latch readback |
| sda_dly_wr | input | 1 | SDA delay register write strobe |
| sda_dly_in | input | 4 | SDA delay write value (clocks) |
| sda_dly_q | output | 4 | SDA delay register readback |
| gp_drive_low | input | 1 | Pull request for the plain port pin |
| gp_oe | output | 1 | Plain port pin pull-low enable |
| sda_pin | input | 1 | SDA pin level |
| scl_pin | input | 1 | SCL pin level |
| sda_oe | output | 1 | SDA pull-low enable |
| scl_oe | output | 1 | SCL pull-low enable |
| sda_level | output | 1 | Synchronized SDA read value |
| scl_level | output | 1 | Synchronized SCL read value |

## Verification
The hardest case to reach is the exact edge where a held bit first reaches SDA. That edge depends on when the SCL pin fell, on the two synchronizer stages and on the programmed delay, all at once. The bench parks a bit in the slot with SCL high and checks that it stays put. It then pulls SCL low just after a falling clock edge, so the first sampling edge is known. Finally it samples `sda_oe` and `tx_ready` after every following edge, across a sweep of delay values and both bit polarities, which covers both sides of the switching edge. A similar fall-aligned stimulus pins down the edge where the hold mode clears the SCL latch.

// File: rtl/i2c_pin_pkg.sv
package i2c_pin_pkg;
  localparam int SYNC_STAGES = 2;
  localparam int PIN_COUNT   = 2;
  localparam int IDX_SDA     = 0;
  localparam int IDX_SCL     = 1;

  typedef struct packed {
    logic scl;
    logic sda;
  } bus_lvl_t;
endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_in,
  output logic [N-1:0] sync_out
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], raw_in[g]};
    end
    assign sync_out[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_sda_path.sv
module i2c_sda_path #(
  parameter int DLY_W   = 4,
  parameter int DEF_DLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i2c_mode,
  input  logic             port_bit,
  input  logic             tx_valid,
  input  logic             tx_bit,
  output logic             tx_ready,
  input  logic             scl_sync,
  input  logic             dly_wr,
  input  logic [DLY_W-1:0] dly_in,
  output logic [DLY_W-1:0] dly_q,
  output logic             sda_oe
);
  localparam logic [DLY_W-1:0] CNT_MAX   = '1;
  localparam logic [DLY_W-1:0] DLY_RESET = DLY_W'(DEF_DLY);

  logic             sda_q;
  logic             held_q;
  logic             held_bit_q;
  logic [DLY_W-1:0] low_cnt_q;
  logic             settled;
  logic             take;
  logic             apply;

  // delay configuration register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dly_q <= DLY_RESET;
    else if (dly_wr) dly_q <= dly_in;
  end

  // count system clocks since the synchronized SCL went low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_cnt_q <= '0;
    else if (scl_sync)         low_cnt_q <= '0;
    else if (low_cnt_q != CNT_MAX) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign settled  = !scl_sync && (low_cnt_q >= dly_q);
  assign tx_ready = i2c_mode && !held_q;
  assign take     = tx_valid && tx_ready;
  assign apply    = i2c_mode && held_q && settled;

  // one-entry holding slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q     <= 1'b0;
      held_bit_q <= 1'b1;
    end else if (!i2c_mode) begin
      held_q <= 1'b0;
    end else if (take) begin
      held_q     <= 1'b1;
      held_bit_q <= tx_bit;
    end else if (apply) begin
      held_q <= 1'b0;
    end
  end

  // SDA output register: tracks port latch out of mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sda_q <= 1'b1;
    else if (!i2c_mode) sda_q <= port_bit;
    else if (apply)     sda_q <= held_bit_q;
  end

  assign sda_oe = i2c_mode && !sda_q;

  // R5
  sda_frozen_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_mode && scl_sync) |=> $stable(sda_q));

  // R4
  sda_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_mode && (low_cnt_q < dly_q)) |=> $stable(sda_q));

  // R6
  take_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
endmodule

// File: rtl/i2c_scl_path.sv
module i2c_scl_path (
  input  logic clk,
  input  logic rst_n,
  input  logic i2c_mode,
  input  logic hold_en,
  input  logic gen_scl,
  input  logic latch_wr,
  input  logic latch_wdata,
  input  logic scl_sync,
  output logic latch_q,
  output logic scl_oe
);
  logic scl_prev_q;
  logic scl_fell;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_prev_q <= 1'b1;
    else        scl_prev_q <= scl_sync;
  end

  assign scl_fell = scl_prev_q && !scl_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               latch_q <= 1'b1;
    else if (latch_wr)                        latch_q <= latch_wdata;
    else if (i2c_mode && hold_en && scl_fell) latch_q <= 1'b0;
  end

  assign scl_oe = i2c_mode && (!gen_scl || !latch_q);

  // R8
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_mode && hold_en && scl_prev_q && !scl_sync && !latch_wr) |=> !latch_q);

  // R9
  latch_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_en && !latch_wr) |=> $stable(latch_q));
endmodule

// File: rtl/i2c_pin_ctrl.sv
module i2c_pin_ctrl
  import i2c_pin_pkg::*;
#(
  parameter int DLY_W   = 4,
  parameter int DEF_DLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i2c_mode,
  input  logic             sda_port_q,
  input  logic             tx_valid,
  input  logic             tx_bit,
  output logic             tx_ready,
  input  logic             gen_scl,
  input  logic             scl_hold_en,
  input  logic             scl_latch_wr,
  input  logic             scl_latch_wdata,
  output logic             scl_latch_q,
  input  logic             sda_dly_wr,
  input  logic [DLY_W-1:0] sda_dly_in,
  output logic [DLY_W-1:0] sda_dly_q,
  input  logic             gp_drive_low,
  output logic             gp_oe,
  input  logic             sda_pin,
  input  logic             scl_pin,
  output logic             sda_oe,
  output logic             scl_oe,
  output logic             sda_level,
  output logic             scl_level
);
  logic [PIN_COUNT-1:0] raw_pins;
  logic [PIN_COUNT-1:0] synced;
  bus_lvl_t             lvl;

  assign raw_pins[IDX_SDA] = sda_pin;
  assign raw_pins[IDX_SCL] = scl_pin;

  i2c_pin_sync #(.N(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (raw_pins),
    .sync_out (synced)
  );

  assign lvl.sda   = synced[IDX_SDA];
  assign lvl.scl   = synced[IDX_SCL];
  assign sda_level = lvl.sda;
  assign scl_level = lvl.scl;

  i2c_sda_path #(.DLY_W(DLY_W), .DEF_DLY(DEF_DLY)) u_sda (
    .clk      (clk),
    .rst_n    (rst_n),
    .i2c_mode (i2c_mode),
    .port_bit (sda_port_q),
    .tx_valid (tx_valid),
    .tx_bit   (tx_bit),
    .tx_ready (tx_ready),
    .scl_sync (lvl.scl),
    .dly_wr   (sda_dly_wr),
    .dly_in   (sda_dly_in),
    .dly_q    (sda_dly_q),
    .sda_oe   (sda_oe)
  );

  i2c_scl_path u_scl (
    .clk         (clk),
    .rst_n       (rst_n),
    .i2c_mode    (i2c_mode),
    .hold_en     (scl_hold_en),
    .gen_scl     (gen_scl),
    .latch_wr    (scl_latch_wr),
    .latch_wdata (scl_latch_wdata),
    .scl_sync    (lvl.scl),
    .latch_q     (scl_latch_q),
    .scl_oe      (scl_oe)
  );

  // third pin stays a plain port in every mode
  assign gp_oe = gp_drive_low;

  // R2
  off_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !i2c_mode |-> (!sda_oe && !scl_oe && !tx_ready));

  // R7
  scl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(scl_pin, 2) == 1'b0 && $past(rst_n, 2) |-> !scl_level);
endmodule

// File: tb/i2c_pin_ctrl_test.sv
module i2c_pin_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic i2c_mode = 0, sda_port_q = 1, tx_valid = 0, tx_bit = 0;
  logic gen_scl = 1, scl_hold_en = 0, scl_latch_wr = 0, scl_latch_wdata = 1;
  logic sda_dly_wr = 0, gp_drive_low = 0;
  logic [3:0] sda_dly_in = '0;
  logic ext_sda_low = 0, ext_scl_low = 0;
  logic tx_ready, scl_latch_q, gp_oe, sda_oe, scl_oe, sda_level, scl_level;
  logic [3:0] sda_dly_q;
  logic sda_pin, scl_pin;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign sda_pin = !(sda_oe || ext_sda_low);
  assign scl_pin = !(scl_oe || ext_scl_low);

  i2c_pin_ctrl uut (
    .clk(clk), .rst_n(rst_n), .i2c_mode(i2c_mode), .sda_port_q(sda_port_q),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_ready(tx_ready),
    .gen_scl(gen_scl), .scl_hold_en(scl_hold_en), .scl_latch_wr(scl_latch_wr),
    .scl_latch_wdata(scl_latch_wdata), .scl_latch_q(scl_latch_q),
    .sda_dly_wr(sda_dly_wr), .sda_dly_in(sda_dly_in), .sda_dly_q(sda_dly_q),
    .gp_drive_low(gp_drive_low), .gp_oe(gp_oe), .sda_pin(sda_pin),
    .scl_pin(scl_pin), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .sda_level(sda_level), .scl_level(scl_level)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edge_sample();
    @(posedge clk); #1;
  endtask

  task automatic wait_edges(input int n);
    for (int i = 0; i < n; i++) edge_sample();
  endtask

  task automatic set_dly(input int d);
    @(negedge clk); sda_dly_wr = 1; sda_dly_in = 4'(d);
    @(negedge clk); sda_dly_wr = 0;
  endtask

  task automatic write_latch(input logic v);
    @(negedge clk); scl_latch_wr = 1; scl_latch_wdata = v;
    @(negedge clk); scl_latch_wr = 0;
  endtask

  // offer a bit; it is taken on the next edge when ready
  task automatic offer(input logic b);
    @(negedge clk); tx_valid = 1; tx_bit = b;
    edge_sample();
    @(negedge clk); tx_valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_edges(3);
    @(negedge clk); rst_n = 1;
    edge_sample();
    // R1 reset state
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 tx_ready", tx_ready, 0);
    chk("R1 latch", scl_latch_q, 1);
    chk("R1 dly", sda_dly_q, 2);

    // R2 mode off: offers ignored, pins released
    for (int pv = 0; pv < 2; pv++) begin
      @(negedge clk); sda_port_q = pv[0]; gen_scl = 0;
      offer(1'b0);
      wait_edges(2);
      chk("R2 sda_oe", sda_oe, 0);
      chk("R2 scl_oe", scl_oe, 0);
      chk("R2 tx_ready", tx_ready, 0);
    end
    @(negedge clk); gen_scl = 1;

    // R3 initial SDA level on mode entry
    for (int pv = 0; pv < 2; pv++) begin
      @(negedge clk); sda_port_q = pv[0];
      wait_edges(2);
      @(negedge clk); i2c_mode = 1; #1;
      chk("R3 sda_oe at entry", sda_oe, pv == 0);
      @(negedge clk); i2c_mode = 0;
    end

    // R4 R5 R6 R12 sweep over delay and bit polarity
    for (int d = 0; d < 6; d++) begin
      for (int b = 0; b < 2; b++) begin
        @(negedge clk); ext_scl_low = 0; sda_port_q = !b[0];
        set_dly(d);
        chk("R12 dly readback", sda_dly_q, d);
        @(negedge clk); i2c_mode = 1;
        wait_edges(4);
        offer(b[0]);
        chk("R6 ready after take", tx_ready, 0);
        wait_edges(6);
        chk("R5 held while SCL high", sda_oe, b);
        @(negedge clk); ext_scl_low = 1;
        for (int k = 0; k <= d + 3; k++) begin
          edge_sample();
          chk("R4 sda_oe vs edge", sda_oe, (k >= d + 2) ? !b : b);
          chk("R6 ready vs edge", tx_ready, (k >= d + 2) ? 1 : 0);
        end
        @(negedge clk); ext_scl_low = 0; i2c_mode = 0;
      end
    end

    // R6 back-to-back bits with SCL settled low
    set_dly(2);
    @(negedge clk); i2c_mode = 1; ext_scl_low = 1;
    wait_edges(8);
    for (int i = 0; i < 6; i++) begin
      logic bv;
      bv = (i % 3) != 1;
      offer(bv);
      chk("R6 ready held", tx_ready, 0);
      edge_sample();
      chk("R6 applied next edge", sda_oe, !bv);
      chk("R6 ready again", tx_ready, 1);
    end
    @(negedge clk); ext_scl_low = 0; ext_sda_low = 0;

    // R7 read values follow pins with two-edge latency
    for (int i = 0; i < 8; i++) begin
      logic v;
      v = (i % 3) == 0;
      @(negedge clk); ext_scl_low = !v; ext_sda_low = v;
      edge_sample();
      edge_sample();
      chk("R7 scl_level", scl_level, v);
      chk("R7 sda_level", sda_level, !v && !sda_oe);
    end
    @(negedge clk); ext_scl_low = 0; ext_sda_low = 0; gen_scl = 0;
    wait_edges(3);
    chk("R7 scl_level while driven", scl_level, 0);
    @(negedge clk); gen_scl = 1;
    wait_edges(3);

    // R8 hold mode clears latch at k0+2
    write_latch(1'b1);
    @(negedge clk); scl_hold_en = 1; ext_scl_low = 1;
    for (int k = 0; k < 4; k++) begin
      edge_sample();
      chk("R8 latch vs edge", scl_latch_q, (k >= 2) ? 0 : 1);
    end
    @(negedge clk); ext_scl_low = 0;
    wait_edges(3);
    chk("R8 stretched scl_oe", scl_oe, 1);
    chk("R8 stretched level", scl_level, 0);
    write_latch(1'b1);
    #1;
    chk("R8 release", scl_oe, 0);

    // R9 no clear without hold mode
    @(negedge clk); scl_hold_en = 0;
    wait_edges(3);
    @(negedge clk); ext_scl_low = 1;
    wait_edges(6);
    chk("R9 latch kept", scl_latch_q, 1);
    @(negedge clk); ext_scl_low = 0;
    wait_edges(3);

    // R10 scl_oe truth table
    for (int c = 0; c < 8; c++) begin
      write_latch(c[2]);
      @(negedge clk); i2c_mode = c[0]; gen_scl = c[1]; #1;
      chk("R10 scl_oe", scl_oe, c[0] && (!c[1] || !c[2]));
    end
    write_latch(1'b1);
    @(negedge clk); gen_scl = 1;

    // R11 plain port pin unaffected by mode
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); i2c_mode = c[0]; gp_drive_low = c[1]; #1;
      chk("R11 gp_oe", gp_oe, c[1]);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule